// File: doc/BRIEF.md
# Bit-Serial Binary Adder

This block adds two unsigned W-bit numbers using one full adder that is reused over W clock cycles. Both operands are loaded in parallel into two right-shifting registers. On each enabled cycle the two least significant bits go into the full adder together with a stored carry bit. The sum bit enters the top of the augend register, so the augend register holds the finished sum after W enabled cycles.

The carry is a single bit of machine state. It is updated as a JK flip-flop. The carry is set when both incoming bits are 1, cleared when both are 0, and otherwise keeps its value. A cycle counter raises a completion flag after exactly W enabled steps. After that, the block ignores the shift enable until the next load. The caller loads the operands, then drives the shift enable for as many cycles as it likes, with gaps where it needs them. When the flag is high, the caller reads the sum and the final carry.

Top module: `bitser_add`

## Requirements
- R1: After reset, `sum_out` is 0, `carry_out` is 0 and `done` is 0.
- R2: A cycle with `load` high puts `a_in` on `sum_out` after the next edge. The same edge clears `carry_out` and `done` and restarts the step count.
- R3: After W enabled step cycles that follow a load, `sum_out` equals (a_in + b_in) mod 2^W.
- R4: At completion, `carry_out` equals bit W of the (W+1)-bit sum a_in + b_in.
- R5: `done` stays 0 through the first W-1 steps after a load. It is 1 after the edge of the W-th step.
- R6: While `done` is 1 and `load` is low, `shift_en` has no effect: `sum_out`, `carry_out` and `done` keep their values.
- R7: A cycle with `load`, `clr` and `shift_en` all low changes nothing visible. Idle gaps between steps therefore leave the final result unchanged.
- R8: A cycle with `clr` high and `load` low clears `carry_out` and performs no shift, even if `shift_en` is high. The step count is kept, so the rest of the addition continues without the carry that was dropped.
- R9: `load` takes priority over `clr` and `shift_en` in the same cycle.
- R10: Each step shifts `sum_out` right by one bit. After the step, `carry_out` is 1 if both incoming LSBs were 1, is 0 if both were 0, and otherwise keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Parallel load of both operands; also clears the carry and the step count |
| clr | input | 1 | Synchronous carry clear; no shift in that cycle |
| shift_en | input | 1 | Enables one serial add step |
| a_in | input | W | Augend for parallel load |
| b_in | input | W | Addend for parallel load |
| sum_out | output | W | Augend/sum register contents |
| carry_out | output | 1 | Stored carry; the final carry out once done is high |
| done | output | 1 | High once W steps have completed since the last load |

## Verification
The bench builds two instances, one with W = 8 and one with W = 3. With W = 3, all 64 operand pairs can be run exhaustively, so every carry path through a short word is covered. With W = 8, random operands with random idle gaps are combined with directed cases. The directed cases cover all-ones overflow, alternating bit patterns, a carry dropped part-way through by `clr`, and a reload that interrupts an addition. The W = 8 runs also show the generate and kill rules of the carry over several consecutive steps.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_LOAD  = 2'd2,
    OP_STEP  = 2'd3
  } bsa_op_e;

  // one-bit sum of a full adder
  function automatic logic fa_sum(input logic x, input logic y, input logic q);
    return x ^ y ^ q;
  endfunction

  // set term of the carry flip-flop
  function automatic logic carry_set(input logic x, input logic y);
    return x & y;
  endfunction

  // reset term of the carry flip-flop
  function automatic logic carry_rst(input logic x, input logic y);
    return ~(x | y);
  endfunction

  // JK next-state rule
  function automatic logic jk_next(input logic q, input logic j, input logic k);
    logic n;
    case ({j, k})
      2'b00:   n = q;
      2'b01:   n = 1'b0;
      2'b10:   n = 1'b1;
      default: n = ~q;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/bsa_shreg.sv
module bsa_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  input  logic         ser_in,
  output logic [W-1:0] q,
  output logic         ser_out
);
  logic [W-1:0] nxt;

  generate
    if (W == 1) begin : g_one
      always_comb nxt = ser_in;
    end else begin : g_many
      always_comb nxt = {ser_in, q[W-1:1]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= nxt;
  end

  assign ser_out = q[0];
endmodule

// File: rtl/bsa_carry.sv
module bsa_carry (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic en,
  input  logic j,
  input  logic k,
  output logic q
);
  import bsa_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (clear) q <= 1'b0;
    else if (en)    q <= jk_next(q, j, k);
  end
endmodule

// File: rtl/bsa_seq.sv
module bsa_seq #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic adv,
  output logic done
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (adv)     cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LAST);
endmodule

// File: rtl/bitser_add.sv
module bitser_add #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         clr,
  input  logic         shift_en,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] sum_out,
  output logic         carry_out,
  output logic         done
);
  import bsa_pkg::*;

  bsa_op_e     op;
  logic        advance;
  logic        x_bit, y_bit, s_bit;
  logic        j_in, k_in;
  logic        carry_q;
  logic [W-1:0] addend_q;

  // operation decode: load > clear > step
  always_comb begin
    if (load)                  op = OP_LOAD;
    else if (clr)              op = OP_CLEAR;
    else if (shift_en && !done) op = OP_STEP;
    else                       op = OP_IDLE;
  end

  assign advance = (op == OP_STEP);
  assign s_bit   = fa_sum(x_bit, y_bit, carry_q);
  assign j_in    = carry_set(x_bit, y_bit);
  assign k_in    = carry_rst(x_bit, y_bit);

  bsa_shreg #(.W(W)) u_aug (
    .clk(clk), .rst_n(rst_n), .load(op == OP_LOAD), .shift(advance),
    .din(a_in), .ser_in(s_bit), .q(sum_out), .ser_out(x_bit)
  );

  bsa_shreg #(.W(W)) u_add (
    .clk(clk), .rst_n(rst_n), .load(op == OP_LOAD), .shift(advance),
    .din(b_in), .ser_in(1'b0), .q(addend_q), .ser_out(y_bit)
  );

  bsa_carry u_cy (
    .clk(clk), .rst_n(rst_n),
    .clear(op == OP_LOAD || op == OP_CLEAR), .en(advance),
    .j(j_in), .k(k_in), .q(carry_q)
  );

  bsa_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .restart(op == OP_LOAD), .adv(advance), .done(done)
  );

  assign carry_out = carry_q;
endmodule

// File: rtl/bsa_chk.sv
module bsa_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load,
  input logic         clr,
  input logic         shift_en,
  input logic [W-1:0] a_in,
  input logic [W-1:0] sum_out,
  input logic         carry_out,
  input logic         done,
  input logic         advance,
  input logic         x_bit,
  input logic         y_bit
);
  // R2, R9
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sum_out == $past(a_in)) && !carry_out && !done);

  // R6
  a_r6_hold_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done && $stable(sum_out) && $stable(carry_out));

  // R7
  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr && !shift_en) |=> $stable(sum_out) && $stable(carry_out) && $stable(done));

  // R8
  a_r8_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !load) |=> !carry_out && $stable(sum_out) && $stable(done));

  // R10 generate / kill
  a_r10_gen: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && x_bit && y_bit) |=> carry_out);
  a_r10_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !x_bit && !y_bit) |=> !carry_out);

  // R6: no step while complete
  a_r6_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !advance);

  generate
    if (W > 1) begin : g_sh
      // R10 shift direction
      a_r10_shift: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> sum_out[W-2:0] == $past(sum_out[W-1:1]));
    end
  endgenerate
endmodule

bind bitser_add bsa_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .clr(clr), .shift_en(shift_en),
  .a_in(a_in), .sum_out(sum_out), .carry_out(carry_out), .done(done),
  .advance(advance), .x_bit(x_bit), .y_bit(y_bit)
);

// File: tb/bitser_add_test.sv
module bitser_add_test;
  localparam int W  = 8;
  localparam int W3 = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         load, clr, sh;
  logic [W-1:0] a, b, so;
  logic         co, dn;

  logic          l3, c3, s3;
  logic [W3-1:0] a3, b3, so3;
  logic          co3, dn3;

  int checks = 0, fails = 0;
  bit finished = 0;

  bitser_add #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .load(load), .clr(clr), .shift_en(sh),
    .a_in(a), .b_in(b), .sum_out(so), .carry_out(co), .done(dn)
  );

  bitser_add #(.W(W3)) uut3 (
    .clk(clk), .rst_n(rst_n), .load(l3), .clr(c3), .shift_en(s3),
    .a_in(a3), .b_in(b3), .sum_out(so3), .carry_out(co3), .done(dn3)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ripple model, carry dropped after step 'kill' (0 = never)
  function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y, input int kill);
    logic c = 1'b0;
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      r[i] = x[i] ^ y[i] ^ c;
      c = (x[i] & y[i]) | (c & (x[i] | y[i]));
      if (i + 1 == kill) c = 1'b0;
    end
    return {c, r};
  endfunction

  task automatic cyc(input logic ld, input logic cl, input logic s,
                     input logic [W-1:0] av, input logic [W-1:0] bv);
    load = ld; clr = cl; sh = s; a = av; b = bv;
    @(posedge clk);
    @(negedge clk);
    load = 0; clr = 0; sh = 0;
  endtask

  task automatic run_add(input logic [W-1:0] av, input logic [W-1:0] bv, input bit gaps);
    logic [W:0] e;
    logic [W-1:0] held;
    e = av + bv;
    cyc(1, 0, 0, av, bv);
    chk("R2 load value", so, av);
    chk("R2 carry clear", co, 0);
    chk("R2 done clear", dn, 0);
    for (int i = 0; i < W; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        held = so;
        cyc(0, 0, 0, 0, 0);
        chk("R7 idle hold", so, held);
      end
      chk("R5 done early", dn, 0);
      cyc(0, 0, 1, 0, 0);
    end
    chk("R5 done after W", dn, 1);
    chk("R3 sum", so, e[W-1:0]);
    chk("R4 carry", co, e[W]);
    cyc(0, 0, 1, 0, 0);
    chk("R6 sum ignored", so, e[W-1:0]);
    chk("R6 carry ignored", co, e[W]);
    chk("R6 done kept", dn, 1);
  endtask

  initial begin
    load = 0; clr = 0; sh = 0; a = 0; b = 0;
    l3 = 0; c3 = 0; s3 = 0; a3 = 0; b3 = 0;
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    chk("R1 sum", so, 0);
    chk("R1 carry", co, 0);
    chk("R1 done", dn, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_add(8'h00, 8'h00, 0);
    run_add(8'hFF, 8'h01, 0);
    run_add(8'hFF, 8'hFF, 1);
    run_add(8'hAA, 8'h55, 0);
    run_add(8'h80, 8'h80, 1);
    for (int n = 0; n < 24; n++) run_add(W'($urandom), W'($urandom), 1);

    // R10 generate then keep, then kill
    cyc(1, 0, 0, 8'h03, 8'h01);
    cyc(0, 0, 1, 0, 0);
    chk("R10 generate", co, 1);
    cyc(0, 0, 1, 0, 0);
    chk("R10 keep", co, 1);
    chk("R10 shift", so, 8'h00);
    cyc(1, 0, 0, 8'h01, 8'h01);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 1, 0, 0);
    chk("R10 kill", co, 0);

    // R8 clear part-way, even with shift_en high
    begin
      logic [W:0] e;
      logic [W-1:0] held;
      e = ref_add(8'hFF, 8'h01, 1);
      cyc(1, 0, 0, 8'hFF, 8'h01);
      cyc(0, 0, 1, 0, 0);
      chk("R8 pre carry", co, 1);
      held = so;
      cyc(0, 1, 1, 0, 0);
      chk("R8 carry cleared", co, 0);
      chk("R8 no shift", so, held);
      for (int i = 1; i < W; i++) cyc(0, 0, 1, 0, 0);
      chk("R8 count kept", dn, 1);
      chk("R8 sum", so, e[W-1:0]);
      chk("R8 carry", co, e[W]);
    end

    // R9 load wins over clr and shift_en mid-addition
    cyc(1, 0, 0, 8'h0F, 8'hF1);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(1, 1, 1, 8'h3C, 8'hC4);
    chk("R9 loaded", so, 8'h3C);
    chk("R9 carry", co, 0);
    chk("R9 done", dn, 0);
    for (int i = 0; i < W; i++) cyc(0, 0, 1, 0, 0);
    chk("R9 sum", so, 8'h00);
    chk("R9 carry out", co, 1);

    // W = 3 exhaustive
    for (int x = 0; x < 8; x++) begin
      for (int y = 0; y < 8; y++) begin
        logic [3:0] e3;
        e3 = 4'(x + y);
        l3 = 1; a3 = 3'(x); b3 = 3'(y);
        @(posedge clk); @(negedge clk);
        l3 = 0; s3 = 1;
        repeat (W3) @(posedge clk);
        @(negedge clk);
        s3 = 0;
        chk("R3 w3 sum", so3, e3[2:0]);
        chk("R4 w3 carry", co3, e3[3]);
        chk("R5 w3 done", dn3, 1);
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule